// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block connects a 32-bit register datapath to a byte-addressed 32-bit memory bus. A store passes in the register value, the transfer size and the low bits of the byte address. The block returns the bus write word, with the value copied into every lane it could land in, and a per-lane write strobe. A load passes in the word read from the bus. The block picks out the addressed byte or halfword and widens it to 32 bits, with zeros or with copies of the field's top bit. The bus word is little-endian: byte offset 0 is bits 7:0 and offset 3 is bits 31:24. Consecutive words therefore sit four byte addresses apart.

Alignment is checked on every access. A word must start at offset 0. A halfword must start at an even offset. A byte may start anywhere. A misaligned access raises a fault flag, blocks every strobe and returns zero as load data. Address arithmetic, bus timing and fault handling are left to the surrounding pipeline. With `OUT_REG` set to 1 (the default), all outputs pass through one register stage that clears on reset. With `OUT_REG` set to 0, the block is purely combinational.

Top module: `lsa_aligner`

## Requirements
- R1: `size_i` encodes the transfer size: 00 is byte, 01 is halfword, 10 and 11 are word. `align_fault_o` is high for a word when `off_i` is not 00, and for a halfword when `off_i[0]` is 1. It is never high for a byte. It is driven for loads and stores alike.
- R2: `wr_data_o` holds `wr_reg_i[7:0]` copied into all four byte lanes for a byte, `wr_reg_i[15:0]` copied into both halves for a halfword, and `wr_reg_i` unchanged for a word.
- R3: For an aligned store, `wr_strb_o` (bit n enables byte lane n, bits n*8+7..n*8) is 4'b1111 for a word. For a halfword it is 4'b0011 when `off_i[1]` is 0 and 4'b1100 when it is 1. For a byte it has only bit `off_i` set.
- R4: With `st_en_i` low, `wr_strb_o` is 4'b0000.
- R5: While `align_fault_o` is high, `wr_strb_o` is 4'b0000.
- R6: An aligned byte load returns bits `off_i`*8+7..`off_i`*8 of `rd_word_i` in bits 7:0. Bits 31:8 are zero when `ld_signed_i` is 0 and copies of bit 7 of the field when it is 1.
- R7: An aligned halfword load returns the half selected by `off_i[1]` (0 picks bits 15:0, 1 picks bits 31:16) in bits 15:0. Bits 31:16 are zero-filled or sign-filled as in R6.
- R8: An aligned word load returns `rd_word_i` unchanged, whatever `ld_signed_i` holds.
- R9: A misaligned load returns `rd_data_o` equal to zero.
- R10: `ld_signed_i` has no effect on `wr_data_o` or `wr_strb_o`.
- R11: With `OUT_REG`=1, each output shows the result for the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are zero. With `OUT_REG`=0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| size_i | input | 2 | Transfer size code |
| off_i | input | 2 | Low byte-address bits |
| ld_signed_i | input | 1 | Sign-extend a sub-word load |
| st_en_i | input | 1 | Access is a store; enables strobes |
| wr_reg_i | input | 32 | Register value to store |
| rd_word_i | input | 32 | Word read from the bus |
| wr_data_o | output | 32 | Lane-replicated write word |
| wr_strb_o | output | 4 | Per-lane write enables |
| rd_data_o | output | 32 | Selected and extended load value |
| align_fault_o | output | 1 | Misaligned access flag |

## Verification
A wrong lane decode shows up at once as a strobe on the wrong lane, or as a load that returns a neighbouring byte. Both appear in the same cycle, or one cycle later when the register stage is on. A fault detector that is out of step with the size code shows as strobes that survive on a misaligned store, or as nonzero load data where zero is due. An error in the extension logic appears only when the selected field's top bit is set, so stimulus drives fields with both sign values at every offset. Every mismatch surfaces within one clock of the inputs that cause it, because the block keeps no state beyond the single output register.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } acc_size_e;

  // Bytes covered by one access of the given size on a bus of 'lanes' bytes.
  function automatic int unsigned size_bytes(acc_size_e s, int unsigned lanes);
    case (s)
      SZ_BYTE: size_bytes = 1;
      SZ_HALF: size_bytes = 2;
      default: size_bytes = lanes;
    endcase
  endfunction

endpackage

// File: rtl/lsa_fault_check.sv
module lsa_fault_check
  import lsa_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] off,
  output logic             misalign
);
  logic [OFF_W-1:0] need_zero;

  // Offset bits below the access size must be zero.
  always_comb begin
    need_zero = OFF_W'(size_bytes(size, LANES) - 1);
    misalign  = |(off & need_zero);
  end
endmodule

// File: rtl/lsa_store_path.sv
module lsa_store_path
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] reg_val,
  output logic [DATA_W-1:0] lane_data,
  output logic [LANES-1:0]  lane_hit
);
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    localparam int HALF_SLOT = ln / 2;
    localparam int IN_HALF   = ln % 2;

    always_comb begin
      case (size)
        SZ_BYTE: begin
          lane_data[ln*8 +: 8] = reg_val[7:0];
          lane_hit[ln]         = (off == OFF_W'(ln));
        end
        SZ_HALF: begin
          lane_data[ln*8 +: 8] = reg_val[IN_HALF*8 +: 8];
          lane_hit[ln]         = (off[OFF_W-1:1] == (OFF_W-1)'(HALF_SLOT));
        end
        default: begin
          lane_data[ln*8 +: 8] = reg_val[ln*8 +: 8];
          lane_hit[ln]         = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/lsa_load_path.sv
module lsa_load_path
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic              sign_ext,
  input  logic [DATA_W-1:0] bus_word,
  output logic [DATA_W-1:0] value
);
  function automatic logic [DATA_W-1:0] widen8(logic [7:0] v, logic s);
    widen8 = {{(DATA_W-8){s & v[7]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] widen16(logic [15:0] v, logic s);
    widen16 = {{(DATA_W-16){s & v[15]}}, v};
  endfunction

  logic [DATA_W-1:0] byte_aligned;
  logic [DATA_W-1:0] half_aligned;

  always_comb begin
    byte_aligned = bus_word >> {off, 3'b000};
    half_aligned = bus_word >> {off[OFF_W-1:1], 4'b0000};
    case (size)
      SZ_BYTE: value = widen8(byte_aligned[7:0], sign_ext);
      SZ_HALF: value = widen16(half_aligned[15:0], sign_ext);
      default: value = bus_word;
    endcase
  end
endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner
  import lsa_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int LANES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              ld_signed_i,
  input  logic              st_en_i,
  input  logic [DATA_W-1:0] wr_reg_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [LANES-1:0]  wr_strb_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              align_fault_o
);
  acc_size_e         acc_size;
  logic              misalign_evt;
  logic [DATA_W-1:0] store_word;
  logic [LANES-1:0]  lane_hit;
  logic [LANES-1:0]  strb_next;
  logic [DATA_W-1:0] load_value;
  logic [DATA_W-1:0] rd_next;
  logic              store_go;

  assign acc_size = acc_size_e'(size_i);

  lsa_fault_check #(.LANES(LANES)) u_fault (
    .size     (acc_size),
    .off      (off_i),
    .misalign (misalign_evt)
  );

  lsa_store_path #(.DATA_W(DATA_W)) u_store (
    .size      (acc_size),
    .off       (off_i),
    .reg_val   (wr_reg_i),
    .lane_data (store_word),
    .lane_hit  (lane_hit)
  );

  lsa_load_path #(.DATA_W(DATA_W)) u_load (
    .size     (acc_size),
    .off      (off_i),
    .sign_ext (ld_signed_i),
    .bus_word (rd_word_i),
    .value    (load_value)
  );

  assign store_go  = st_en_i & ~misalign_evt;
  assign strb_next = store_go ? lane_hit : '0;
  assign rd_next   = misalign_evt ? '0 : load_value;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wr_data_o     <= '0;
        wr_strb_o     <= '0;
        rd_data_o     <= '0;
        align_fault_o <= 1'b0;
      end else begin
        wr_data_o     <= store_word;
        wr_strb_o     <= strb_next;
        rd_data_o     <= rd_next;
        align_fault_o <= misalign_evt;
      end
    end
  end else begin : g_comb
    assign wr_data_o     = store_word;
    assign wr_strb_o     = strb_next;
    assign rd_data_o     = rd_next;
    assign align_fault_o = misalign_evt;
  end
endmodule

// File: rtl/lsa_aligner_chk.sv
module lsa_aligner_chk #(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int LANES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        size_i,
  input logic [OFF_W-1:0]  off_i,
  input logic              ld_signed_i,
  input logic              st_en_i,
  input logic [DATA_W-1:0] wr_data_o,
  input logic [LANES-1:0]  wr_strb_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              align_fault_o
);
  // Inputs aligned to the cycle in which their outputs appear.
  logic [1:0]       c_size;
  logic [OFF_W-1:0] c_off;
  logic             c_signed;
  logic             c_st;

  if (OUT_REG) begin : g_dly
    logic [1:0]       q_size;
    logic [OFF_W-1:0] q_off;
    logic             q_signed;
    logic             q_st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_size   <= '0;
        q_off    <= '0;
        q_signed <= 1'b0;
        q_st     <= 1'b0;
      end else begin
        q_size   <= size_i;
        q_off    <= off_i;
        q_signed <= ld_signed_i;
        q_st     <= st_en_i;
      end
    end
    assign c_size   = q_size;
    assign c_off    = q_off;
    assign c_signed = q_signed;
    assign c_st     = q_st;
  end else begin : g_dir
    assign c_size   = size_i;
    assign c_off    = off_i;
    assign c_signed = ld_signed_i;
    assign c_st     = st_en_i;
  end

  a_r1_byte_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (c_size == 2'b00) |-> !align_fault_o);

  a_r1_word_offset_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (c_size[1] && c_off != '0) |-> align_fault_o);

  a_r2_byte_replicated: assert property (@(posedge clk) disable iff (!rst_n)
    (c_size == 2'b00) |-> (wr_data_o == {LANES{wr_data_o[7:0]}}));

  a_r3_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (c_st && c_size == 2'b00) |-> ($countones(wr_strb_o) == 1));

  a_r3_half_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (c_st && c_size == 2'b01 && !align_fault_o) |-> ($countones(wr_strb_o) == 2));

  a_r4_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !c_st |-> (wr_strb_o == '0));

  a_r5_fault_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault_o |-> (wr_strb_o == '0));

  a_r6_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (c_signed && c_size == 2'b00) |-> (rd_data_o[DATA_W-1:8] == {(DATA_W-8){rd_data_o[7]}}));

  a_r9_fault_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault_o |-> (rd_data_o == '0));
endmodule

bind lsa_aligner lsa_aligner_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .size_i        (size_i),
  .off_i         (off_i),
  .ld_signed_i   (ld_signed_i),
  .st_en_i       (st_en_i),
  .wr_data_o     (wr_data_o),
  .wr_strb_o     (wr_strb_o),
  .rd_data_o     (rd_data_o),
  .align_fault_o (align_fault_o)
);

// File: tb/lsa_aligner_test.sv
module lsa_aligner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  size_i = 2'b10;
  logic [1:0]  off_i = 2'b00;
  logic        ld_signed_i = 1'b1;
  logic        st_en_i = 1'b1;
  logic [31:0] wr_reg_i = 32'hFFFF_FFFF;
  logic [31:0] rd_word_i = 32'hFFFF_FFFF;

  logic [31:0] q_wdata, c_wdata, q_rdata, c_rdata;
  logic [3:0]  q_strb, c_strb;
  logic        q_fault, c_fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string note = "";

  always #5 clk = ~clk;

  lsa_aligner #(.DATA_W(32), .OUT_REG(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .size_i(size_i), .off_i(off_i),
    .ld_signed_i(ld_signed_i), .st_en_i(st_en_i), .wr_reg_i(wr_reg_i),
    .rd_word_i(rd_word_i), .wr_data_o(q_wdata), .wr_strb_o(q_strb),
    .rd_data_o(q_rdata), .align_fault_o(q_fault));

  lsa_aligner #(.DATA_W(32), .OUT_REG(1'b0)) uut_c (
    .clk(clk), .rst_n(rst_n), .size_i(size_i), .off_i(off_i),
    .ld_signed_i(ld_signed_i), .st_en_i(st_en_i), .wr_reg_i(wr_reg_i),
    .rd_word_i(rd_word_i), .wr_data_o(c_wdata), .wr_strb_o(c_strb),
    .rd_data_o(c_rdata), .align_fault_o(c_fault));

  // Reference model written from the requirements.
  function automatic bit ref_fault(logic [1:0] sz, logic [1:0] off);
    if (sz == 2'b00)      return 1'b0;
    else if (sz == 2'b01) return off[0];
    else                  return off != 2'b00;
  endfunction

  function automatic logic [31:0] ref_wdata(logic [1:0] sz, logic [31:0] r);
    if (sz == 2'b00)      return {r[7:0], r[7:0], r[7:0], r[7:0]};
    else if (sz == 2'b01) return {r[15:0], r[15:0]};
    else                  return r;
  endfunction

  function automatic logic [3:0] ref_strb(logic [1:0] sz, logic [1:0] off, logic st);
    if (!st || ref_fault(sz, off)) return 4'b0000;
    if (sz == 2'b00)      return 4'b0001 << off;
    else if (sz == 2'b01) return off[1] ? 4'b1100 : 4'b0011;
    else                  return 4'b1111;
  endfunction

  function automatic logic [31:0] ref_rdata(logic [1:0] sz, logic [1:0] off,
                                            logic sg, logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    if (ref_fault(sz, off)) return 32'h0;
    case (off)
      2'd0: b = w[7:0];
      2'd1: b = w[15:8];
      2'd2: b = w[23:16];
      default: b = w[31:24];
    endcase
    h = off[1] ? w[31:16] : w[15:0];
    if (sz == 2'b00)      return (sg && b[7])  ? {24'hFFFFFF, b} : {24'h0, b};
    else if (sz == 2'b01) return (sg && h[15]) ? {16'hFFFF, h}   : {16'h0, h};
    else                  return w;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, note, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] sz, logic [1:0] off, logic sg, logic st,
                       logic [31:0] rv, logic [31:0] rw);
    logic        ef;
    logic [31:0] ewd, erd;
    logic [3:0]  es;
    string       stag, rtag;
    @(negedge clk);
    size_i = sz; off_i = off; ld_signed_i = sg; st_en_i = st;
    wr_reg_i = rv; rd_word_i = rw;
    ef  = ref_fault(sz, off);
    ewd = ref_wdata(sz, rv);
    es  = ref_strb(sz, off, st);
    erd = ref_rdata(sz, off, sg, rw);
    stag = ef ? "R5 strb" : (!st ? "R4 strb" : "R3 strb");
    rtag = ef ? "R9 rdata" : (sz == 2'b00 ? "R6 rdata" : (sz == 2'b01 ? "R7 rdata" : "R8 rdata"));
    #1;
    check("R1 fault", {31'h0, c_fault}, {31'h0, ef});
    check("R2 wdata", c_wdata, ewd);
    check(stag, {28'h0, c_strb}, {28'h0, es});
    check(rtag, c_rdata, erd);
    @(posedge clk);
    #1;
    check("R11 fault", {31'h0, q_fault}, {31'h0, ef});
    check("R11 wdata", q_wdata, ewd);
    check("R11 strb", {28'h0, q_strb}, {28'h0, es});
    check("R11 rdata", q_rdata, erd);
  endtask

  initial begin
    void'($urandom(32'd1357));
    // R11: registered outputs held at zero during reset
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset wdata", q_wdata, 32'h0);
    check("R11 reset strb", {28'h0, q_strb}, 32'h0);
    check("R11 reset rdata", q_rdata, 32'h0);
    check("R11 reset fault", {31'h0, q_fault}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed: every size and offset, both sign settings, sign bits set
    for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 4; off++)
        for (int sg = 0; sg < 2; sg++)
          apply(2'(sz), 2'(off), sg[0], 1'b1, 32'h8765_C3A1, 32'h80FF_7F81);
    // R4: loads produce no strobes
    note = "R4";
    for (int off = 0; off < 4; off++) apply(2'b00, 2'(off), 1'b0, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0);
    // R5/R9: misaligned store and load
    note = "R5 R9";
    apply(2'b10, 2'b10, 1'b0, 1'b1, 32'hDEAD_BEEF, 32'hFFFF_FFFF);
    apply(2'b01, 2'b11, 1'b1, 1'b0, 32'hDEAD_BEEF, 32'h8000_8000);
    // R10: signed flag on a store changes nothing
    note = "R10";
    apply(2'b00, 2'b10, 1'b1, 1'b1, 32'h0000_00F0, 32'h0);
    apply(2'b01, 2'b10, 1'b1, 1'b1, 32'h0000_9001, 32'h0);
    // R8: word load with signed flag stays unchanged
    note = "R8";
    apply(2'b10, 2'b00, 1'b1, 1'b0, 32'h0, 32'hF000_000F);
    note = "rand";
    for (int i = 0; i < 600; i++)
      apply(2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule